// File: doc/BRIEF.md
# Override Output Source Multiplexer

This block decides which 6-bit value is driven on an output port. The candidates are two stored codes, a 5-bit external input port, all zeros, and a held snapshot of the output itself. Two external level pins choose among them: a route-enable pin and a hold-select pin. When route-enable is high and hold-select is low, a source that software picks through a shared 2-bit mode field is used.

Changes to that mode field only take effect when the serial interface reports the end of a bus transaction with a one-cycle commit pulse. The stored codes come from slow storage. A store-ready flag says when the codes are settled, and the block only accepts a new code while that flag is high. Whenever hold-select rises, the block captures the value on the output at that moment and keeps it for later use.

Both pins are asynchronous. They pass through a two-stage synchroniser, and edges are detected on the synchronised copies.

Top module: `out_src_mux`

## Requirements
- R1: After reset the output is all zeros, and the committed source is stored code A.
- R2: With route-enable low and hold-select low, the output is all zeros, whatever the codes, the input port or the mode.
- R3: With route-enable high and hold-select high, the output is the 5-bit input port with a 0 in bit 5. It follows the input port one clock later.
- R4: With route-enable high and hold-select low, the output follows the committed source. A committed mode of 2'b00 selects stored code A, 2'b01 selects stored code B, and 2'b10 selects the zero-extended input port.
- R5: A new mode value is adopted only in a cycle where the commit pulse is high. The committed source changes on that clock edge, and the output changes one edge later. Without a commit, the mode input has no effect.
- R6: Committing the reserved mode 2'b11 leaves the previously committed source in place.
- R7: A stored code is taken in only in cycles where store-ready is high. While store-ready is low, the last code taken in keeps being used. A code taken in reaches the output two edges after the cycle it is taken in.
- R8: On a rising edge of the synchronised hold-select, the output value that was present just before the edge is captured. While route-enable is low and hold-select is high, the output shows that captured value, even if the codes change afterwards.
- R9: Both pins are synchronised through two flops before use. A pin change is visible on the output after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| commit_i | input | 1 | One-cycle pulse marking the end of a bus transaction |
| mode_i | input | 2 | Shared mode field: 00 code A, 01 code B, 10 input port, 11 reserved |
| store_rdy_i | input | 1 | High when the stored codes are settled |
| code_a_i | input | 6 | Stored code A |
| code_b_i | input | 6 | Stored code B |
| ext_i | input | 5 | External input port, synchronous to clk |
| hold_sel_i | input | 1 | Asynchronous hold-select pin |
| route_en_i | input | 1 | Asynchronous route-enable pin |
| y_o | output | 6 | Selected output value |

## Verification
The assertions assume that the commit pulse, the mode field, the codes and the input port are synchronous to the clock. They also assume that the pins are only judged on their synchronised copies, so every output property is stated against the synchroniser outputs and not the raw pins.

The stimulus drives every input on the falling edge. It holds each pin level for at least three edges before any result is compared, so no check depends on how far a pin is through the synchroniser, apart from the deliberate latency check. The commit pulse is always exactly one cycle wide.

// File: rtl/out_src_pkg.sv
package out_src_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    SRC_CODE_A = 2'd0,
    SRC_CODE_B = 2'd1,
    SRC_EXT    = 2'd2
  } src_e;

  localparam logic [MODE_W-1:0] MODE_RESERVED = 2'b11;

  function automatic logic mode_is_reserved(input logic [MODE_W-1:0] m);
    return m == MODE_RESERVED;
  endfunction
endpackage

// File: rtl/osm_rst_sync.sv
module osm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/osm_pin_sync.sv
module osm_pin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_s_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign pin_s_o = stage_q[STAGES-1];
endmodule

// File: rtl/osm_src_commit.sv
module osm_src_commit
  import out_src_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [MODE_W-1:0] mode_i,
  output src_e              src_o
);
  src_e src_q, src_d;
  logic src_en;

  always_comb begin
    src_en = commit_i && !mode_is_reserved(mode_i);
    src_d  = src_q;
    if (src_en) begin
      unique case (mode_i)
        2'b00:   src_d = SRC_CODE_A;
        2'b01:   src_d = SRC_CODE_B;
        default: src_d = SRC_EXT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= SRC_CODE_A;
    else if (src_en) src_q <= src_d;
  end

  assign src_o = src_q;
endmodule

// File: rtl/osm_code_stage.sv
module osm_code_stage #(
  parameter int DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_rdy_i,
  input  logic [DATA_W-1:0] code_a_i,
  input  logic [DATA_W-1:0] code_b_i,
  output logic [DATA_W-1:0] shown_a_o,
  output logic [DATA_W-1:0] shown_b_o
);
  logic [DATA_W-1:0] shown_a_q, shown_b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shown_a_q <= '0;
      shown_b_q <= '0;
    end else if (store_rdy_i) begin
      shown_a_q <= code_a_i;
      shown_b_q <= code_b_i;
    end
  end

  assign shown_a_o = shown_a_q;
  assign shown_b_o = shown_b_q;
endmodule

// File: rtl/osm_out_mux.sv
module osm_out_mux
  import out_src_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int EXT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_s_i,
  input  logic              route_s_i,
  input  src_e              src_i,
  input  logic [DATA_W-1:0] shown_a_i,
  input  logic [DATA_W-1:0] shown_b_i,
  input  logic [EXT_W-1:0]  ext_i,
  output logic              hold_prev_o,
  output logic [DATA_W-1:0] held_o,
  output logic [DATA_W-1:0] y_o
);
  localparam int PAD_W = DATA_W - EXT_W;

  logic              hold_prev_q;
  logic [DATA_W-1:0] held_q, held_d;
  logic [DATA_W-1:0] y_q, y_d;
  logic [DATA_W-1:0] ext_z;
  logic              hold_rise;

  always_comb begin
    ext_z     = {{PAD_W{1'b0}}, ext_i};
    hold_rise = hold_s_i && !hold_prev_q;
    held_d    = hold_rise ? y_q : held_q;
    unique case ({route_s_i, hold_s_i})
      2'b00: y_d = '0;
      2'b01: y_d = held_d;
      2'b11: y_d = ext_z;
      default: begin
        unique case (src_i)
          SRC_CODE_A: y_d = shown_a_i;
          SRC_CODE_B: y_d = shown_b_i;
          default:    y_d = ext_z;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_prev_q <= 1'b0;
      held_q      <= '0;
      y_q         <= '0;
    end else begin
      hold_prev_q <= hold_s_i;
      if (hold_rise) held_q <= held_d;
      y_q <= y_d;
    end
  end

  assign hold_prev_o = hold_prev_q;
  assign held_o      = held_q;
  assign y_o         = y_q;
endmodule

// File: rtl/out_src_mux.sv
module out_src_mux
  import out_src_pkg::*;
#(
  parameter int DATA_W      = 6,
  parameter int EXT_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [1:0]        mode_i,
  input  logic              store_rdy_i,
  input  logic [DATA_W-1:0] code_a_i,
  input  logic [DATA_W-1:0] code_b_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic              hold_sel_i,
  input  logic              route_en_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int PIN_W = 2;

  logic              rst_int_n;
  logic [PIN_W-1:0]  pins_s;
  logic              hold_s, route_s, hold_prev;
  src_e              src_q;
  logic [DATA_W-1:0] shown_a, shown_b, held_q;

  osm_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  osm_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) i_pin_sync (
    .clk(clk), .rst_n(rst_int_n),
    .pin_i({hold_sel_i, route_en_i}), .pin_s_o(pins_s)
  );

  assign hold_s  = pins_s[1];
  assign route_s = pins_s[0];

  osm_src_commit i_src_commit (
    .clk(clk), .rst_n(rst_int_n), .commit_i(commit_i),
    .mode_i(mode_i), .src_o(src_q)
  );

  osm_code_stage #(.DATA_W(DATA_W)) i_code_stage (
    .clk(clk), .rst_n(rst_int_n), .store_rdy_i(store_rdy_i),
    .code_a_i(code_a_i), .code_b_i(code_b_i),
    .shown_a_o(shown_a), .shown_b_o(shown_b)
  );

  osm_out_mux #(.DATA_W(DATA_W), .EXT_W(EXT_W)) i_out_mux (
    .clk(clk), .rst_n(rst_int_n), .hold_s_i(hold_s), .route_s_i(route_s),
    .src_i(src_q), .shown_a_i(shown_a), .shown_b_i(shown_b), .ext_i(ext_i),
    .hold_prev_o(hold_prev), .held_o(held_q), .y_o(y_o)
  );
endmodule

// File: rtl/chk_out_src_mux.sv
module chk_out_src_mux #(
  parameter int DATA_W = 6,
  parameter int EXT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit_i,
  input logic [1:0]        mode_i,
  input logic [EXT_W-1:0]  ext_i,
  input logic [DATA_W-1:0] y_o,
  input logic              hold_s,
  input logic              hold_prev,
  input logic              route_s,
  input logic [1:0]        src_q,
  input logic [DATA_W-1:0] held_q
);
  localparam int PAD_W = DATA_W - EXT_W;

  p_zero_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!route_s && !hold_s) |=> (y_o == '0));

  p_ext_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (route_s && hold_s) |=> (y_o == {{PAD_W{1'b0}}, $past(ext_i)}));

  p_ext_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (route_s && !hold_s && src_q == 2'd2) |=> (y_o == {{PAD_W{1'b0}}, $past(ext_i)}));

  p_no_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(src_q));

  p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && mode_i == 2'b11) |=> $stable(src_q));

  p_snap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_s && !hold_prev) |=> (held_q == $past(y_o)));

  p_held_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!route_s && hold_s) |=> (y_o == held_q));
endmodule

bind out_src_mux chk_out_src_mux #(.DATA_W(DATA_W), .EXT_W(EXT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .mode_i(mode_i),
  .ext_i(ext_i), .y_o(y_o), .hold_s(hold_s), .hold_prev(hold_prev),
  .route_s(route_s), .src_q(src_q), .held_q(held_q)
);

// File: tb/test_out_src_mux.sv
`timescale 1ns/1ps
module test_out_src_mux;
  logic       clk = 1'b0;
  logic       rst_n, commit, store_rdy, hold_sel, route_en;
  logic [1:0] mode;
  logic [5:0] code_a, code_b, y;
  logic [4:0] ext;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  out_src_mux i_out_src_mux (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .mode_i(mode),
    .store_rdy_i(store_rdy), .code_a_i(code_a), .code_b_i(code_b),
    .ext_i(ext), .hold_sel_i(hold_sel), .route_en_i(route_en), .y_o(y)
  );

  task automatic check(input string req, input logic [5:0] exp);
    n_cmp++;
    if (y !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, y, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic h, input logic r);
    hold_sel = h; route_en = r;
    wait_n(3);
  endtask

  task automatic pulse_commit(input logic [1:0] m);
    mode = m; commit = 1'b1;
    wait_n(1);
    commit = 1'b0;
    wait_n(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; commit = 0; store_rdy = 1; hold_sel = 0; route_en = 0;
    mode = 0; code_a = 0; code_b = 0; ext = 0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    check("R1 reset output", 6'h00);
    // R1: committed source after reset is code A
    code_a = 6'h2C; set_pins(1'b0, 1'b1); wait_n(2);
    check("R1 reset source", 6'h2C);
    set_pins(1'b0, 1'b0);

    // R2: zeros for all source settings
    for (int i = 0; i < 8; i++) begin
      code_a = 6'(i * 9 + 1); code_b = 6'(63 - i); ext = 5'(i * 3 + 1);
      pulse_commit(2'(i % 4));
      wait_n(2);
      check("R2 off zeros", 6'h00);
    end
    pulse_commit(2'b00);

    // R3: sweep of the whole input port
    set_pins(1'b1, 1'b1);
    for (int v = 0; v < 32; v++) begin
      ext = 5'(v);
      wait_n(1);
      check("R3 ext pass", {1'b0, 5'(v)});
    end

    // R9: pin latency of three edges
    code_a = 6'h2A; ext = 5'h15; wait_n(2);
    hold_sel = 1'b0;
    wait_n(2);
    check("R9 not before third edge", 6'h15);
    wait_n(1);
    check("R9 after third edge", 6'h2A);

    // R4: every selectable source over a sweep of values
    for (int s = 0; s < 3; s++) begin
      pulse_commit(2'(s));
      for (int v = 0; v < 64; v += 7) begin
        code_a = 6'(v); code_b = ~6'(v); ext = 5'(v);
        wait_n(2);
        check("R4 committed source",
              (s == 0) ? 6'(v) : (s == 1) ? ~6'(v) : {1'b0, 5'(v)});
      end
    end

    // R5: mode change without commit has no effect; commit latency
    code_a = 6'h11; code_b = 6'h22; ext = 5'h03;
    pulse_commit(2'b00); wait_n(1);
    mode = 2'b01; wait_n(3);
    check("R5 no commit", 6'h11);
    commit = 1'b1; wait_n(1); commit = 1'b0;
    check("R5 one edge after commit", 6'h11);
    wait_n(1);
    check("R5 two edges after commit", 6'h22);

    // R6: reserved mode keeps previous source
    pulse_commit(2'b11); wait_n(1);
    check("R6 reserved keeps B", 6'h22);
    pulse_commit(2'b10); pulse_commit(2'b11); wait_n(1);
    check("R6 reserved keeps ext", 6'h03);
    pulse_commit(2'b00); wait_n(1);
    check("R6 leaves via A", 6'h11);

    // R7: store-ready gating
    store_rdy = 1'b0; code_a = 6'h3E; wait_n(3);
    check("R7 not ready holds", 6'h11);
    store_rdy = 1'b1; wait_n(1);
    check("R7 one edge after ready", 6'h11);
    wait_n(1);
    check("R7 two edges after ready", 6'h3E);

    // R8: snapshot on hold rise while output shows code A
    code_a = 6'h1B; wait_n(2);
    set_pins(1'b1, 1'b0);
    check("R8 snapshot shown", 6'h1B);
    code_a = 6'h05; wait_n(3);
    check("R8 snapshot unaffected", 6'h1B);
    set_pins(1'b0, 1'b1);
    check("R8 back to code A", 6'h05);
    ext = 5'h0A;
    set_pins(1'b1, 1'b1);
    check("R8 ext while holding", 6'h0A);
    set_pins(1'b1, 1'b0);
    check("R8 snapshot of earlier value", 6'h05);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule